// File: doc/BRIEF.md
# Two-Backplane LCD Drive Sequencer

This block sequences the drive waveforms for a multiplexed liquid-crystal panel with two backplane (common) lines and 45 segment lines, which together show 90 segments. It emits no analog voltages. Each output carries a 2-bit level code (low, mid or high), and an external level shifter turns these codes into the three bias voltages. An oscillator-rate tick paces the sequence. One full frame takes 512 ticks and is split into four equal phases. Within a frame each common is selected once with positive polarity and once with inverted polarity, so every pixel sees zero net DC.

The 90 display bits and the control fields come from a serial receiver that is not part of this block. A blank control turns every segment off and leaves the display bits untouched. A sleep control freezes the sequence and pulls the drive lines low. Some lines can take another role. The first segment lines can become plain digital outputs. The two lines shared with the key scanner can carry segments 44 and 45, or they can pass through the scanner's drive bits.

Top module: `lcd_half_duty_drv`

## Requirements
- R1: Level codes are 0 = low, 1 = mid, 2 = high; code 3 never appears on a common. While `rst_n` is low, every output code is 0 (low) at once, so each segment equals its common and is off. After `rst_n` rises, the first clock edge starts the frame at phase 0.
- R2: The phases run 0,1,2,3 and then repeat. Phase 0 puts COM1 (`com_lvl[1:0]`) high and COM2 (`com_lvl[3:2]`) mid. Phase 1 puts COM2 high and COM1 mid. Phase 2 puts COM1 low and COM2 mid. Phase 3 puts COM2 low and COM1 mid.
- R3: Each phase lasts 128 `osc_tick` pulses and a frame lasts 512. The sequence advances only on clocks where `osc_tick` is high.
- R4: Segment line k shows display bit 2k while COM1 is selected and bit 2k+1 while COM2 is selected. An on segment drives the extreme opposite to the selected common's level. An off segment drives the same level as the selected common.
- R5: While `blank` is high, every segment line drives the selected common's level, whatever the display bits hold.
- R6: While `sleep` is high, both commons and every line in segment role drive low, and the phase counter holds its place. When sleep ends, the sequence resumes in the phase where it stopped.
- R7: The first min(`port_cnt`,4) segment lines act as digital outputs. Line i drives high (2) when `port_val[i]` is 1 and low (0) when it is 0. This holds whatever the state of sleep or blank.
- R8: Key line j (`ks_lvl[2j+1:2j]`) carries segment line 43+j (bits 86+2j and 87+2j) when `ks_seg_en[j]` is 1. When `ks_seg_en[j]` is 0, the line drives high or low following `ks_drive[j]`.
- R9: Every output is registered. A change on any input shows at the outputs after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-clock pulse per oscillator period |
| sleep | input | 1 | Freeze sequence, drive lines low |
| blank | input | 1 | Force all segments off |
| disp_bits | input | 90 | Display bits, two per segment line |
| port_cnt | input | 3 | Number of leading lines used as digital outputs |
| port_val | input | 4 | Values for the digital-output lines |
| ks_seg_en | input | 2 | Per key line: 1 = segment role |
| ks_drive | input | 2 | Key-scan drive bits for key role |
| com_lvl | output | 4 | Common level codes, COM1 in the low pair |
| seg_lvl | output | 86 | Level codes for segment lines 0..42 |
| ks_lvl | output | 4 | Level codes for the two shared key lines |

## Verification
Because the phase state lives in a single counter, a wrong counter value shows up at once as a wrong common pattern, or as a phase that runs the wrong number of cycles. The bench therefore times whole frames and single phases, and it stops the sequence mid-phase with sleep and then resumes it. A wrong polarity or bit-select choice shows within one clock as a segment that matches its common when it should oppose it. The pattern table covers every phase with on, off and blanked data. Role-select errors show on the first clock after the select changes, so the bench checks both edge lines of each remapped range.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    typedef enum logic [1:0] {
        LV_LOW  = 2'd0,
        LV_MID  = 2'd1,
        LV_HIGH = 2'd2
    } lvl_e;

    localparam int NUM_PHASES = 4;
    localparam int NUM_COMS   = 2;

    // Drive for a segment given the selected common level and its pixel state.
    function automatic logic [1:0] seg_level(input logic [1:0] com_sel, input logic on);
        logic [1:0] r;
        if (on) begin
            r = (com_sel == LV_HIGH) ? LV_LOW : LV_HIGH;
        end else begin
            r = com_sel;
        end
        return r;
    endfunction

    function automatic logic [1:0] pin_level(input logic b);
        return b ? LV_HIGH : LV_LOW;
    endfunction

endpackage

// File: rtl/lcd_phase_gen.sv
module lcd_phase_gen
    import lcd_drv_pkg::*;
#(
    parameter int FRAME_DIV = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold,
    output logic [1:0] phase
);
    localparam int PH_LEN = FRAME_DIV / NUM_PHASES;
    localparam int CW     = (PH_LEN > 1) ? $clog2(PH_LEN) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    ph;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick && !hold) begin
            if (st_q.cnt == CW'(PH_LEN - 1)) begin
                st_d.cnt = '0;
                st_d.ph  = st_q.ph + 2'd1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;

endmodule

// File: rtl/lcd_com_map.sv
module lcd_com_map
    import lcd_drv_pkg::*;
(
    input  logic [1:0]            phase,
    output logic [2*NUM_COMS-1:0] com,
    output logic                  sel_idx,
    output logic [1:0]            sel_lvl
);
    // phase[0] picks the common, phase[1] picks the inverted half of the frame
    assign sel_idx = phase[0];
    assign sel_lvl = phase[1] ? LV_LOW : LV_HIGH;

    for (genvar c = 0; c < NUM_COMS; c++) begin : g_com
        assign com[2*c +: 2] = (sel_idx == 1'(c)) ? sel_lvl : LV_MID;
    end

endmodule

// File: rtl/lcd_seg_map.sv
module lcd_seg_map
    import lcd_drv_pkg::*;
#(
    parameter int NUM_LINES = 45
) (
    input  logic [2*NUM_LINES-1:0] bits,
    input  logic                   sel_idx,
    input  logic [1:0]             sel_lvl,
    input  logic                   blank,
    output logic [2*NUM_LINES-1:0] lvl
);
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        logic on;
        assign on = !blank && (sel_idx ? bits[2*k+1] : bits[2*k]);
        assign lvl[2*k +: 2] = seg_level(sel_lvl, on);
    end

endmodule

// File: rtl/lcd_half_duty_drv.sv
module lcd_half_duty_drv
    import lcd_drv_pkg::*;
#(
    parameter int NUM_SEG_LINES = 45,
    parameter int NUM_PORTS     = 4,
    parameter int NUM_KS_SEG    = 2,
    parameter int FRAME_DIV     = 512
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   osc_tick,
    input  logic                                   sleep,
    input  logic                                   blank,
    input  logic [2*NUM_SEG_LINES-1:0]             disp_bits,
    input  logic [$clog2(NUM_PORTS+1)-1:0]         port_cnt,
    input  logic [NUM_PORTS-1:0]                   port_val,
    input  logic [NUM_KS_SEG-1:0]                  ks_seg_en,
    input  logic [NUM_KS_SEG-1:0]                  ks_drive,
    output logic [2*NUM_COMS-1:0]                  com_lvl,
    output logic [2*(NUM_SEG_LINES-NUM_KS_SEG)-1:0] seg_lvl,
    output logic [2*NUM_KS_SEG-1:0]                ks_lvl
);
    localparam int NUM_MAIN = NUM_SEG_LINES - NUM_KS_SEG;

    typedef struct packed {
        logic [2*NUM_COMS-1:0]   com;
        logic [2*NUM_MAIN-1:0]   seg;
        logic [2*NUM_KS_SEG-1:0] ks;
    } out_t;

    out_t out_d, out_q;

    logic [1:0]                   phase;
    logic [2*NUM_COMS-1:0]        com_raw;
    logic                         sel_idx;
    logic [1:0]                   sel_lvl;
    logic [2*NUM_SEG_LINES-1:0]   seg_all;

    lcd_phase_gen #(.FRAME_DIV(FRAME_DIV)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (osc_tick),
        .hold  (sleep),
        .phase (phase)
    );

    lcd_com_map u_com (
        .phase   (phase),
        .com     (com_raw),
        .sel_idx (sel_idx),
        .sel_lvl (sel_lvl)
    );

    lcd_seg_map #(.NUM_LINES(NUM_SEG_LINES)) u_seg (
        .bits    (disp_bits),
        .sel_idx (sel_idx),
        .sel_lvl (sel_lvl),
        .blank   (blank),
        .lvl     (seg_all)
    );

    always_comb begin
        out_d.com = sleep ? '0 : com_raw;
        out_d.seg = sleep ? '0 : seg_all[2*NUM_MAIN-1:0];
        // leading lines handed over to digital-output role
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (i < int'(port_cnt)) begin
                out_d.seg[2*i +: 2] = pin_level(port_val[i]);
            end
        end
        for (int j = 0; j < NUM_KS_SEG; j++) begin
            if (ks_seg_en[j]) begin
                out_d.ks[2*j +: 2] = sleep ? 2'(LV_LOW) : seg_all[2*(NUM_MAIN+j) +: 2];
            end else begin
                out_d.ks[2*j +: 2] = pin_level(ks_drive[j]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign com_lvl = out_q.com;
    assign seg_lvl = out_q.seg;
    assign ks_lvl  = out_q.ks;

endmodule

// File: rtl/lcd_half_duty_drv_chk.sv
module lcd_half_duty_drv_chk #(
    parameter int NM = 43
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep,
    input logic          blank,
    input logic [3:0]    com_lvl,
    input logic [2*NM-1:0] seg_lvl
);
    logic [1:0] c1, c2, sel, last;
    assign c1   = com_lvl[1:0];
    assign c2   = com_lvl[3:2];
    assign sel  = (c1 != 2'd1) ? c1 : c2;
    assign last = seg_lvl[2*NM-1 -: 2];

    // R1: no illegal code on the commons
    p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (c1 != 2'd3) && (c2 != 2'd3));

    // R2: exactly one common away from mid when awake
    p_one_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> ((c1 == 2'd1) != (c2 == 2'd1)));

    // R4: a segment line never sits at mid while driven
    p_seg_extreme_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> (last != 2'd1));

    // R5: blanked segments follow the selected common
    p_blank_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !sleep) |=> (last == sel));

    // R6: sleep drives commons and segments low
    p_sleep_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (com_lvl == 4'd0) && (last == 2'd0));

endmodule

bind lcd_half_duty_drv lcd_half_duty_drv_chk #(.NM(NUM_SEG_LINES - NUM_KS_SEG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep   (sleep),
    .blank   (blank),
    .com_lvl (com_lvl),
    .seg_lvl (seg_lvl)
);

// File: tb/lcd_half_duty_drv_tb.sv
module lcd_half_duty_drv_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] L = 2'd0, M = 2'd1, H = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        sleep = 1'b0;
    logic        blank = 1'b0;
    logic [89:0] disp_bits = '0;
    logic [2:0]  port_cnt = '0;
    logic [3:0]  port_val = '0;
    logic [1:0]  ks_seg_en = 2'b11;
    logic [1:0]  ks_drive = '0;
    logic [3:0]  com_lvl;
    logic [85:0] seg_lvl;
    logic [3:0]  ks_lvl;
    logic        half_tick = 1'b0;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_half_duty_drv u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sleep(sleep), .blank(blank),
        .disp_bits(disp_bits), .port_cnt(port_cnt), .port_val(port_val),
        .ks_seg_en(ks_seg_en), .ks_drive(ks_drive),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl), .ks_lvl(ks_lvl)
    );

    typedef struct packed {
        logic       de;
        logic       dodd;
        logic       bl;
        logic [1:0] ph;
        logic [1:0] ec1;
        logic [1:0] ec2;
        logic [1:0] es;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 1'b0, 1'b0, 2'd0, H, M, L},
        '{1'b0, 1'b1, 1'b0, 2'd0, H, M, H},
        '{1'b0, 1'b1, 1'b0, 2'd1, M, H, L},
        '{1'b1, 1'b0, 1'b0, 2'd1, M, H, H},
        '{1'b1, 1'b1, 1'b0, 2'd2, L, M, H},
        '{1'b0, 1'b1, 1'b0, 2'd2, L, M, L},
        '{1'b1, 1'b1, 1'b0, 2'd3, M, L, H},
        '{1'b1, 1'b0, 1'b0, 2'd3, M, L, L},
        '{1'b1, 1'b1, 1'b1, 2'd0, H, M, H},
        '{1'b1, 1'b1, 1'b1, 2'd1, M, H, H},
        '{1'b1, 1'b1, 1'b1, 2'd2, L, M, L},
        '{1'b1, 1'b1, 1'b1, 2'd3, M, L, L}
    };

    function automatic logic [3:0] ph_pat(input int p);
        case (p)
            0:       return {M, H};
            1:       return {H, M};
            2:       return {M, L};
            default: return {L, M};
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic goto_phase(input int p);
        while (com_lvl == ph_pat(p)) @(negedge clk);
        while (com_lvl != ph_pat(p)) @(negedge clk);
    endtask

    task automatic set_disp(input logic de, input logic dodd);
        disp_bits = {45{dodd, de}};
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        fork
            forever begin
                @(negedge clk);
                osc_tick = half_tick ? ~osc_tick : 1'b1;
            end
            begin
                repeat (150000) @(posedge clk);
                total++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
                finish_run();
            end
        join_none
    end

    initial begin
        int n;
        // R1: reset state, key line in key role with drive high still low
        ks_seg_en = 2'b00;
        ks_drive  = 2'b11;
        repeat (3) @(negedge clk);
        chk("R1", "com in reset", 32'(com_lvl), 32'd0);
        chk("R1", "seg in reset", 32'(seg_lvl[31:0]), 32'd0);
        chk("R1", "ks in reset", 32'(ks_lvl), 32'd0);
        ks_seg_en = 2'b11;
        ks_drive  = 2'b00;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "first phase after reset", 32'(com_lvl), 32'(ph_pat(0)));

        // R2 R4 R5: pattern table
        foreach (VECS[v]) begin
            set_disp(VECS[v].de, VECS[v].dodd);
            blank = VECS[v].bl;
            goto_phase(int'(VECS[v].ph));
            chk("R2", "com levels", 32'(com_lvl), 32'({VECS[v].ec2, VECS[v].ec1}));
            chk(VECS[v].bl ? "R5" : "R4", "line0", 32'(seg_lvl[1:0]), 32'(VECS[v].es));
            chk(VECS[v].bl ? "R5" : "R4", "line42", 32'(seg_lvl[85:84]), 32'(VECS[v].es));
            chk("R8", "ks line1 as segment", 32'(ks_lvl[3:2]), 32'(VECS[v].es));
        end
        blank = 1'b0;

        // R3: frame and phase lengths
        goto_phase(0);
        n = 0;
        while (com_lvl == ph_pat(0)) begin @(negedge clk); n++; end
        chk("R3", "phase length", 32'(n), 32'd128);
        while (com_lvl != ph_pat(0)) begin @(negedge clk); n++; end
        chk("R3", "frame length", 32'(n), 32'd512);
        half_tick = 1'b1;
        goto_phase(0);
        n = 0;
        while (com_lvl == ph_pat(0)) begin @(negedge clk); n++; end
        while (com_lvl != ph_pat(0)) begin @(negedge clk); n++; end
        chk("R3", "frame length at half tick rate", 32'(n), 32'd1024);
        half_tick = 1'b0;

        // R9: one clock latency
        set_disp(1'b1, 1'b1);
        goto_phase(0);
        chk("R4", "on segment in phase 0", 32'(seg_lvl[85:84]), 32'(L));
        blank = 1'b1;
        #1;
        chk("R9", "no change before edge", 32'(seg_lvl[85:84]), 32'(L));
        @(negedge clk);
        chk("R9", "blank after one edge", 32'(seg_lvl[85:84]), 32'(H));
        blank = 1'b0;

        // R6: sleep, with one port line active
        goto_phase(1);
        port_cnt = 3'd1;
        port_val = 4'b0001;
        @(negedge clk);
        sleep = 1'b1;
        @(negedge clk);
        chk("R6", "com low in sleep", 32'(com_lvl), 32'd0);
        chk("R6", "seg low in sleep", 32'(seg_lvl[85:84]), 32'd0);
        chk("R6", "ks segment low in sleep", 32'(ks_lvl), 32'd0);
        chk("R7", "port line during sleep", 32'(seg_lvl[1:0]), 32'(H));
        repeat (300) @(negedge clk);
        chk("R6", "com still low", 32'(com_lvl), 32'd0);
        sleep = 1'b0;
        @(negedge clk);
        chk("R6", "resume in same phase", 32'(com_lvl), 32'(ph_pat(1)));

        // R7: port role ranges
        set_disp(1'b0, 1'b0);
        port_cnt = 3'd2;
        port_val = 4'b0110;
        goto_phase(0);
        chk("R7", "line0 as port", 32'(seg_lvl[1:0]), 32'(L));
        chk("R7", "line1 as port", 32'(seg_lvl[3:2]), 32'(H));
        chk("R7", "line2 still segment", 32'(seg_lvl[5:4]), 32'(H));
        set_disp(1'b1, 1'b1);
        port_cnt = 3'd7;
        port_val = 4'b1000;
        @(negedge clk);
        chk("R7", "line3 as port at saturated count", 32'(seg_lvl[7:6]), 32'(H));
        chk("R7", "line4 segment at saturated count", 32'(seg_lvl[9:8]), 32'(L));
        port_cnt = 3'd0;

        // R8: key line roles
        ks_seg_en = 2'b01;
        ks_drive  = 2'b10;
        @(negedge clk);
        chk("R8", "ks0 segment", 32'(ks_lvl[1:0]), 32'(L));
        chk("R8", "ks1 key drive high", 32'(ks_lvl[3:2]), 32'(H));
        ks_seg_en = 2'b00;
        ks_drive  = 2'b01;
        @(negedge clk);
        chk("R8", "ks0 key drive high", 32'(ks_lvl[1:0]), 32'(H));
        chk("R8", "ks1 key drive low", 32'(ks_lvl[3:2]), 32'(L));
        ks_seg_en = 2'b11;

        // R1: reset in mid frame
        goto_phase(2);
        rst_n = 1'b0;
        #1;
        chk("R1", "async reset com", 32'(com_lvl), 32'd0);
        chk("R1", "async reset seg", 32'(seg_lvl[85:84]), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "restart at phase 0", 32'(com_lvl), 32'(ph_pat(0)));

        finish_run();
    end

endmodule